// File: doc/BRIEF.md
# Interrupt Summary Aggregator

This block is a second stage of interrupt collection. Below it sit three interrupt groups (receive, transmit and miscellaneous), each with its own cause and mask logic, and each offering one level output. The aggregator keeps one sticky summary bit per group and drives a single host interrupt line. A software mask register decides which summary bits may raise that line.

Software reads the summary to find which groups need service. The read also clears the summary, so no separate acknowledge write is needed. A group whose level is still high simply sets its bit again one cycle later, so a persistent condition is never lost.

A typical handler works in four steps. It writes all ones to the mask on entry. It reads the summary. It services each flagged group. It then unmasks by writing zeros into the group positions. Masking never discards pending summary bits: a bit collected while masked raises the line as soon as the mask opens.

Top module: `irq_summary_agg`

## Requirements
- R1: After reset the summary is 0, every mask bit is 1 (all groups masked), the host line is low and read data is 0.
- R2: A group level that is high in cycle N sets its summary bit from cycle N+1. Group positions are receive = bit 0, transmit = bit 1, miscellaneous = bit 2. The summary is visible through a read of address 0.
- R3: A summary bit stays set after its group level falls, until the summary is read.
- R4: A read strobe to address 0 in cycle N returns the summary held in cycle N on `reg_rdata` in cycle N+1. The same read clears every summary bit whose group level is low in cycle N.
- R5: A group level that is high in the cycle of a summary read leaves that bit set after the read. The next read returns it.
- R6: A write to address 1 loads the mask from `reg_wdata`, where a 1 masks the group at that bit position. A read of address 1 returns the mask. Writing all ones masks every group.
- R7: The host line is registered. It is high in cycle N+1 exactly when, in cycle N, some summary bit is set whose mask bit is 0.
- R8: Masking does not clear the summary. Writing 0 to the group positions of the mask later raises the host line for any bit collected while masked.
- R9: Read data bits above bit 2 are always 0. Writes to address 0 are ignored. Reads of addresses 2 and 3 return 0.
- R10: Reading the mask register leaves the summary unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_lvl | input | NUM_GRP | Interrupt level of each group (bit 0 receive, 1 transmit, 2 miscellaneous) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address (0 summary, 1 mask) |
| reg_wdata | input | NUM_GRP | Write data for the group positions of the mask |
| reg_rdata | output | DATA_W | Read data, valid the cycle after `reg_rd` |
| host_irq | output | 1 | Registered host interrupt line |

## Verification
The sticky summary is internal, so faults in it appear only at the ports. A bit that fails to set or hold shows up as a wrong value on the next summary read, one cycle after the strobe. A clear that is missed or misplaced shows up on the read that follows it. A mask that is wrong, or a gate that is wrong, shows up on `host_irq` within two cycles of the group level or the mask write. The bench therefore pairs every read with an expected word in a queue and checks the host line at fixed cycles after each stimulus.

// File: rtl/irqsum_pkg.sv
package irqsum_pkg;
    localparam int IRQSUM_ADDR_SUM  = 0;
    localparam int IRQSUM_ADDR_MASK = 1;

    typedef enum int {
        GRP_RX   = 0,
        GRP_TX   = 1,
        GRP_MISC = 2
    } grp_pos_e;
endpackage

// File: rtl/irqsum_cause_latch.sv
module irqsum_cause_latch #(
    parameter int NUM_GRP = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_GRP-1:0] grp_lvl,
    input  logic               clr,
    output logic [NUM_GRP-1:0] sum_q
);
    typedef struct packed {
        logic [NUM_GRP-1:0] sum;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.sum = grp_lvl;
        else     st_d.sum = st_q.sum | grp_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum_q = st_q.sum;

    for (genvar i = 0; i < NUM_GRP; i++) begin : g_chk
        assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
            grp_lvl[i] |=> sum_q[i]);
        assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (sum_q[i] && !clr) |=> sum_q[i]);
        assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !grp_lvl[i]) |=> !sum_q[i]);
    end
endmodule

// File: rtl/irqsum_mask_reg.sv
module irqsum_mask_reg #(
    parameter int NUM_GRP = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [NUM_GRP-1:0] wr_bits,
    output logic [NUM_GRP-1:0] mask_q
);
    typedef struct packed {
        logic [NUM_GRP-1:0] mask;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.mask = wr_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mask: '1};
        else        st_q <= st_d;
    end

    assign mask_q = st_q.mask;

    assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mask_q == $past(wr_bits)));
    assert_mask_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q));
endmodule

// File: rtl/irqsum_host_line.sv
module irqsum_host_line #(
    parameter int NUM_GRP = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_GRP-1:0] sum,
    input  logic [NUM_GRP-1:0] mask,
    output logic               irq_q
);
    typedef struct packed {
        logic irq;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(sum & ~mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_q = st_q.irq;

    assert_all_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |=> !irq_q);
    assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sum == '0) |=> !irq_q);
    assert_open_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((sum & ~mask) != '0) |=> irq_q);
endmodule

// File: rtl/irq_summary_agg.sv
module irq_summary_agg
    import irqsum_pkg::*;
#(
    parameter int NUM_GRP = 3,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_GRP-1:0] grp_lvl,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [NUM_GRP-1:0] reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               host_irq
);
    localparam int PAD_W = DATA_W - NUM_GRP;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;

    logic               hit_sum, hit_mask;
    logic [NUM_GRP-1:0] sum_q, mask_q;

    assign hit_sum  = (reg_addr == ADDR_W'(IRQSUM_ADDR_SUM));
    assign hit_mask = (reg_addr == ADDR_W'(IRQSUM_ADDR_MASK));

    irqsum_cause_latch #(.NUM_GRP(NUM_GRP)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .grp_lvl (grp_lvl),
        .clr     (reg_rd && hit_sum),
        .sum_q   (sum_q)
    );

    irqsum_mask_reg #(.NUM_GRP(NUM_GRP)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr && hit_mask),
        .wr_bits (reg_wdata),
        .mask_q  (mask_q)
    );

    irqsum_host_line #(.NUM_GRP(NUM_GRP)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .sum   (sum_q),
        .mask  (mask_q),
        .irq_q (host_irq)
    );

    always_comb begin
        st_d.rdata = '0;
        if (reg_rd) begin
            if (hit_sum)       st_d.rdata = {{PAD_W{1'b0}}, sum_q};
            else if (hit_mask) st_d.rdata = {{PAD_W{1'b0}}, mask_q};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;

    assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:NUM_GRP] == '0);
    assert_mask_read_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && hit_mask && grp_lvl == '0) |=> $stable(sum_q));
endmodule

// File: tb/tb_irq_summary_agg.sv
module tb_irq_summary_agg;
    localparam int CLK_PERIOD = 10;
    localparam int NG = 3;
    localparam int DW = 32;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NG-1:0] grp_lvl = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [NG-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          host_irq;

    irq_summary_agg #(.NUM_GRP(NG), .DATA_W(DW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .grp_lvl(grp_lvl), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .host_irq(host_irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];
    logic          rd_seen = 1'b0;

    always @(posedge clk) rd_seen <= reg_rd;

    // monitor: compare each returned read word with the queued expectation
    always @(negedge clk) begin
        if (rd_seen) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_err++;
                $display("FAIL read with no expectation: actual %h expected none", reg_rdata);
            end else begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    n_err++;
                    $display("FAIL %s: rdata actual %h expected %h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        reg_rd   = 1'b1;
        reg_addr = a;
        tick();
        reg_rd   = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [NG-1:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        tick();
        reg_wr    = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        n_chk++;
        if (host_irq !== e) begin
            n_err++;
            $display("FAIL %s: host_irq actual %b expected %b", t, host_irq, e);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        chk_irq(1'b0, "R1 line low after reset");
        rd(0, 32'h0, "R1 summary empty after reset");
        rd(1, 32'h7, "R1 mask all set after reset");

        // R2 / R3 / R4: receive pulse while masked
        grp_lvl = 3'b001;
        tick();
        grp_lvl = 3'b000;
        tick();
        chk_irq(1'b0, "R6 masked pulse keeps line low");
        rd(0, 32'h1, "R2 R3 receive bit held after pulse");
        rd(0, 32'h0, "R4 summary cleared by read");

        // R6 / R9: unmask by writing zeros to group positions
        wr(1, 3'b000);
        rd(1, 32'h0, "R6 R9 mask readback after unmask");

        // R7 / R5: held transmit level
        grp_lvl = 3'b010;
        tick();
        tick();
        chk_irq(1'b1, "R7 line raised by unmasked transmit");
        rd(0, 32'h2, "R2 transmit bit position");
        rd(0, 32'h2, "R5 held level sets bit again after read");
        grp_lvl = 3'b000;
        tick();
        rd(0, 32'h2, "R5 last re-set survives until read");
        rd(0, 32'h0, "R4 cleared once level gone");
        chk_irq(1'b0, "R7 line falls after summary clears");

        // R9: write to summary address ignored
        wr(0, 3'b111);
        rd(0, 32'h0, "R9 summary write ignored");

        // R8 / R10: collect while masked, then open
        wr(1, 3'b111);
        grp_lvl = 3'b100;
        tick();
        grp_lvl = 3'b000;
        tick();
        chk_irq(1'b0, "R6 all ones masks misc");
        rd(1, 32'h7, "R10 mask read while summary pending");
        wr(1, 3'b000);
        tick();
        chk_irq(1'b1, "R8 unmask raises line for held bit");
        rd(0, 32'h4, "R8 R10 misc bit kept through mask and mask read");
        rd(0, 32'h0, "R4 misc cleared");
        chk_irq(1'b0, "R7 line low after misc cleared");

        // R2 / R9: two groups, unmapped address
        grp_lvl = 3'b011;
        tick();
        grp_lvl = 3'b000;
        rd(0, 32'h3, "R2 receive and transmit together");
        rd(3, 32'h0, "R9 unmapped address reads zero");

        // R5: level arriving in the read cycle
        grp_lvl = 3'b001;
        rd(0, 32'h0, "R5 read returns value before same-cycle level");
        grp_lvl = 3'b000;
        rd(0, 32'h1, "R5 same-cycle level kept for next read");

        tick();
        tick();
        if (exp_q.size() != 0) begin
            n_chk++;
            n_err++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule